// File: doc/BRIEF.md
# Override-Capable Single-Bit Storage Array

This block holds a small column of one-bit storage cells, one per row. A row is picked by decoding a binary row address, and this happens only while the shared access line is high. A picked row whose write strobe is high captures the shared data bit on the next rising clock edge. Rows that are not picked, or that are picked while the strobe is low, keep their value.

Two global force lines override every cell at once, whatever the address, access, strobe or data. When both lines are high, every cell loads 1. When both are low, every cell loads 0. Only when the two lines disagree does the normal select and write path take effect. The next value of each cell comes from a weighted five-input majority vote. Each force line takes two of the votes, and the fifth vote is the data bit when the cell is enabled, or the held bit when it is not.

The output of every cell is wired straight to its own bit of the output vector, with no gating. The stored value can therefore be read at all times, even while the cell is not selected. There is no shared read bus.

Top module: `srm_bit_array`

## Requirements
- R1: A synchronous active-high reset clears every stored bit to 0 at the next rising edge.
- R2: When both force lines are 1 and reset is low, every bit is 1 after the next edge, regardless of access, strobe, address and data.
- R3: When both force lines are 0 and reset is low, every bit is 0 after the next edge, regardless of access, strobe, address and data.
- R4: When the force lines differ and access and strobe are both 1, the addressed row holds the data bit after the next edge.
- R5: When the force lines differ, access is 1 and the strobe is 0 (a read), no bit changes.
- R6: When the force lines differ and access is 0, no bit changes for any strobe or data value.
- R7: A write changes only the addressed row. Bit i of the output belongs to row address i.
- R8: Every output bit shows its cell's stored value in every cycle, including cycles in which that row is not selected.
- R9: Reset takes priority over agreeing force lines.
- R10: Agreeing force lines take priority over a write that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_a | input | 1 | First force line |
| ovr_b | input | 1 | Second force line |
| access | input | 1 | Qualifies the row-address decode |
| rw | input | 1 | Write strobe: 1 writes, 0 reads |
| din | input | 1 | Shared data bit |
| row_addr | input | ADDR_W | Binary row address |
| cell_q | output | ROWS | Stored bit of each row, bit i is row i |

## Verification
Two functions can fall in the same cycle: the forced load from agreeing force lines and an ordinary write to one row. The bench provokes this by driving access and strobe high with a data bit opposite to the forced value, then expecting the whole vector to take the forced value. This includes the addressed row. The exhaustive pass over all thirty-two combinations of force lines, access, strobe and data, against a known prior state, covers the reverse case. There, lines that disagree must let the write through to exactly one row.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // Counts the high inputs and reports whether at least three of five are set.
  function automatic logic maj5(input logic [4:0] v);
    int unsigned ones;
    ones = 0;
    for (int k = 0; k < 5; k++) begin
      ones = ones + int'(v[k]);
    end
    return (ones >= 3);
  endfunction

  // Next state of one cell. Each force line takes two votes, and the fifth vote
  // is the muxed data/held bit. Agreeing lines carry four votes and win.
  // Disagreeing lines leave the fifth vote to decide.
  function automatic logic cell_next(input logic a, input logic b,
                                     input logic en, input logic d,
                                     input logic q);
    logic m;
    m = en ? d : q;
    return maj5({a, a, b, b, m});
  endfunction

endpackage

// File: rtl/srm_row_decode.sv
module srm_row_decode #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              access,
  input  logic [ADDR_W-1:0] row_addr,
  output logic [ROWS-1:0]   row_sel
);

  // One select line per row, high only for the matching address while access is high.
  for (genvar i = 0; i < ROWS; i++) begin : g_sel
    assign row_sel[i] = access && (row_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/srm_bit_cell.sv
module srm_bit_cell
  import srm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ovr_a,
  input  logic ovr_b,
  input  logic sel,
  input  logic rw,
  input  logic din,
  output logic cell_en,
  output logic q
);

  logic q_r;

  assign cell_en = sel & rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= 1'b0;
    end else begin
      q_r <= cell_next(ovr_a, ovr_b, cell_en, din, q_r);
    end
  end

  // Output is never gated.
  assign q = q_r;

endmodule

// File: rtl/srm_bit_array.sv
module srm_bit_array #(
  parameter int ROWS = 8,
  localparam int ADDR_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovr_a,
  input  logic              ovr_b,
  input  logic              access,
  input  logic              rw,
  input  logic              din,
  input  logic [ADDR_W-1:0] row_addr,
  output logic [ROWS-1:0]   cell_q
);

  // Named internal events for the checker.
  logic [ROWS-1:0] row_sel;
  logic [ROWS-1:0] en_vec;

  srm_row_decode #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_dec (
    .access   (access),
    .row_addr (row_addr),
    .row_sel  (row_sel)
  );

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    srm_bit_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .ovr_a   (ovr_a),
      .ovr_b   (ovr_b),
      .sel     (row_sel[i]),
      .rw      (rw),
      .din     (din),
      .cell_en (en_vec[i]),
      .q       (cell_q[i])
    );
  end

endmodule

// File: rtl/srm_bit_array_chk.sv
module srm_bit_array_chk #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ovr_a,
  input logic              ovr_b,
  input logic              access,
  input logic              rw,
  input logic              din,
  input logic [ADDR_W-1:0] row_addr,
  input logic [ROWS-1:0]   cell_q,
  input logic [ROWS-1:0]   row_sel,
  input logic [ROWS-1:0]   en_vec
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cell_q == '0)); // R1 R9

  AST_FORCE_ONES: assert property (@(posedge clk) disable iff (rst)
    (ovr_a && ovr_b) |=> (cell_q == '1)); // R2

  AST_FORCE_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (!ovr_a && !ovr_b) |=> (cell_q == '0)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ((ovr_a != ovr_b) && access && rw && (int'(row_addr) < ROWS))
    |=> (cell_q[$past(row_addr)] == $past(din))); // R4

  AST_UNENABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovr_a != ovr_b) |=> (((cell_q ^ $past(cell_q)) & ~$past(en_vec)) == '0)); // R5

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    !access |-> (row_sel == '0)); // R6

  AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel)); // R7

  AST_EN_WITHIN_SELECT: assert property (@(posedge clk) disable iff (rst)
    (((en_vec & ~row_sel) == '0) && (rw || (en_vec == '0)))); // R7

endmodule

bind srm_bit_array srm_bit_array_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ovr_a    (ovr_a),
  .ovr_b    (ovr_b),
  .access   (access),
  .rw       (rw),
  .din      (din),
  .row_addr (row_addr),
  .cell_q   (cell_q),
  .row_sel  (row_sel),
  .en_vec   (en_vec)
);

// File: tb/test_srm_bit_array.sv
`timescale 1ns/1ps
module test_srm_bit_array;

  localparam int ROWS = 8;
  localparam int AW   = 3;

  typedef struct {
    logic [ROWS-1:0] exp;
    string           tag;
  } sb_item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ovr_a = 1'b1;
  logic            ovr_b = 1'b0;
  logic            access = 1'b0;
  logic            rw = 1'b0;
  logic            din = 1'b0;
  logic [AW-1:0]   row_addr = '0;
  logic [ROWS-1:0] cell_q;

  sb_item_t        sb[$];
  logic [ROWS-1:0] model = '0;
  int              checks = 0;
  int              failures = 0;
  bit              done = 1'b0;

  always #10 clk = ~clk;

  srm_bit_array #(.ROWS(ROWS)) i_srm_bit_array (
    .clk(clk), .rst(rst), .ovr_a(ovr_a), .ovr_b(ovr_b), .access(access),
    .rw(rw), .din(din), .row_addr(row_addr), .cell_q(cell_q)
  );

  // Driver: sets the inputs for one edge and queues the expected post-edge vector.
  task automatic drive(input logic r, input logic a, input logic b, input logic acc,
                       input logic w, input logic d, input logic [AW-1:0] addr,
                       input string tag);
    sb_item_t it;
    logic [ROWS-1:0] nxt;
    @(negedge clk);
    rst = r; ovr_a = a; ovr_b = b; access = acc; rw = w; din = d; row_addr = addr;
    if (r)                  nxt = '0;
    else if (a && b)        nxt = {ROWS{1'b1}};
    else if (!a && !b)      nxt = '0;
    else if (acc && w) begin nxt = model; nxt[addr] = d; end
    else                    nxt = model;
    model = nxt;
    it.exp = nxt;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (!done && sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (cell_q !== it.exp) begin
        failures++;
        $display("FAIL %s: cell_q=%b expected=%b", it.tag, cell_q, it.exp);
      end
    end
  end

  function automatic string tag_for(input logic a, input logic b,
                                    input logic acc, input logic w);
    if (a && b)        return "R2";
    else if (!a && !b) return "R3";
    else if (acc && w) return "R4";
    else if (acc)      return "R5";
    else               return "R6";
  endfunction

  initial begin
    // R1 / R9: reset beats agreeing force lines
    drive(1, 1, 1, 1, 1, 1, 3'd2, "R9");
    drive(1, 1, 1, 0, 0, 0, 3'd0, "R1");
    // R4 / R7: write an alternating pattern row by row
    for (int i = 0; i < ROWS; i++) drive(0, 1, 0, 1, 1, logic'(i % 2), AW'(i), "R4");
    // R5: reads with opposite data leave every bit alone
    for (int i = 0; i < ROWS; i++) drive(0, 0, 1, 1, 0, logic'(~(i % 2)), AW'(i), "R5");
    // R6 / R8: idle cycles with strobe and data toggling, output still visible
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 1, logic'(i % 2), AW'(i), "R8");
    // R7: single-row write leaves neighbours untouched
    drive(0, 0, 1, 1, 1, 1'b1, 3'd4, "R7");
    drive(0, 0, 1, 1, 1, 1'b0, 3'd1, "R7");
    // R10: agreeing lines beat a concurrent opposite write
    drive(0, 1, 1, 1, 1, 1'b0, 3'd5, "R10");
    drive(0, 0, 0, 1, 1, 1'b1, 3'd6, "R10");
    // Exhaustive over force/access/strobe/data, from two prior states per combo
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0] v;
        logic [AW-1:0] ad;
        v = 5'(c);
        ad = AW'((c * 3 + pass) % ROWS);
        // prime the addressed row to the opposite of the data bit
        drive(0, 1, 0, 1, 1, ~v[0], ad, "R4");
        drive(0, v[4], v[3], v[2], v[1], v[0], ad, tag_for(v[4], v[3], v[2], v[1]));
      end
    end
    // R9: reset mid-run with force lines high
    drive(0, 1, 1, 0, 0, 0, 3'd0, "R2");
    drive(1, 1, 1, 1, 1, 1, 3'd7, "R9");
    drive(0, 1, 0, 0, 0, 0, 3'd0, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule